// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Generator

This block produces the bit-rate timing for one channel of a serial interface. It supports three operating modes: oversampled asynchronous, clocked synchronous and smart-card. Each channel instantiates its own copy, so channels can run at different rates.

The rate is set by an 8-bit divisor value N, a 2-bit prescaler code n and, in smart-card mode, a 2-bit cycles-per-bit code. The timing chain has three stages. A 4^n prescaler feeds an (N+1) down-counter, which produces a base tick. A final counter then counts a mode-dependent number of base ticks per bit. The block outputs three single-cycle strobes:
- a bit strobe, once per bit;
- a base-tick strobe, for the asynchronous and smart-card receivers;
- a 16x sampling strobe, in asynchronous mode only.

Any change of settings restarts the whole chain. The first bit after a change therefore takes one full period at the new rate.

Top module: `baud_rate_gen`

## Requirements
- R1: The divisor register resets to 0xFF and is always visible on `rate_rdata`. A cycle with `rate_we` high loads `rate_wdata`, and the new value is visible after that clock edge.
- R2: The base tick occurs once every 4^n × (N+1) clocks. n is the value of `presc_sel`, 0 to 3.
- R3: In asynchronous mode (`card_sel`=0, `sync_sel`=0), `bit_stb` fires once every 32 base ticks.
- R4: In clocked synchronous mode (`card_sel`=0, `sync_sel`=1), `bit_stb` fires once every 4 base ticks. `tick_stb` and `sub_stb` stay low. With N=0 and n=0, the bit period is 4 clocks.
- R5: With `card_sel`=1, smart-card mode applies whatever `sync_sel` is. `bit_stb` fires once every S/2 base ticks, where S comes from `cycles_sel`: 0→32, 1→64, 2→372, 3→256.
- R6: In asynchronous mode, `sub_stb` fires on every second base tick, 16 times per bit. The last of these coincides with `bit_stb`.
- R7: Every strobe is high for exactly one clock. In asynchronous and smart-card modes, `tick_stb` is high in every cycle where `bit_stb` is high.
- R8: A clock edge with `rate_we` high, or with any of `presc_sel`, `cycles_sel`, `sync_sel`, `card_sel` different from its value at the previous edge, is a restart. A restart clears all counters and produces no strobe after that edge. The next strobes then come exactly one full new period after the restart edge.
- R9: While `gen_en` is low, every edge is a restart and all strobes stay low.
- R10: After reset, the remembered settings are all zero. The first edge with different setting inputs is therefore a restart. Reset itself leaves the chain in the same state as a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable; low holds the chain cleared |
| rate_we | input | 1 | Divisor write strobe |
| rate_wdata | input | 8 | Divisor write value N |
| rate_rdata | output | 8 | Current divisor value |
| presc_sel | input | 2 | Prescaler code n, divide by 4^n |
| cycles_sel | input | 2 | Smart-card clocks-per-bit code |
| sync_sel | input | 1 | 1 selects clocked synchronous when not in smart-card mode |
| card_sel | input | 1 | 1 selects smart-card mode |
| bit_stb | output | 1 | One-clock strobe per bit period |
| tick_stb | output | 1 | One-clock strobe per base tick (asynchronous and smart-card) |
| sub_stb | output | 1 | One-clock 16x sampling strobe (asynchronous) |

## Verification
The checker watches the following on every cycle:
- every strobe is one clock wide;
- the sampling strobe only appears with a base tick;
- the bit strobe coincides with a tick outside synchronous mode;
- no tick appears in synchronous mode;
- nothing fires after a restart edge or while the generator is disabled;
- the divisor readback follows writes.

The exact periods under each prescaler, divisor and smart-card code can only be shown by the bench. So can the precedence of smart-card over synchronous mode, the alignment of the first bit after a mid-period write, and the restart caused by reset-time setting values. The bench's reference model counts clocks since the last restart and predicts every strobe.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int RATE_W = 8;
    localparam int SEL_W  = 2;
    localparam int FIN_W  = 8;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_CARD  = 2'd2
    } brg_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] presc;
        logic [SEL_W-1:0] cycles;
        logic             sync_bit;
        logic             card_bit;
    } brg_cfg_t;

    function automatic brg_mode_e cfg_mode(input brg_cfg_t c);
        if (c.card_bit)
            return MODE_CARD;
        else if (c.sync_bit)
            return MODE_SYNC;
        else
            return MODE_ASYNC;
    endfunction

    // Number of base ticks that make one bit.
    function automatic logic [FIN_W-1:0] ticks_per_bit(input brg_mode_e m,
                                                       input logic [SEL_W-1:0] cyc);
        logic [FIN_W-1:0] len;
        case (m)
            MODE_SYNC: len = FIN_W'(4);
            MODE_CARD: begin
                case (cyc)
                    2'd0:    len = FIN_W'(16);
                    2'd1:    len = FIN_W'(32);
                    2'd2:    len = FIN_W'(186);
                    default: len = FIN_W'(128);
                endcase
            end
            default:   len = FIN_W'(32);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/brg_cfg_track.sv
module brg_cfg_track
    import brg_pkg::*;
#(
    parameter int W = RATE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  brg_cfg_t     cfg_in,
    output logic [W-1:0] rate_q,
    output logic [W-1:0] rate_nxt,
    output logic         restart
);

    typedef struct packed {
        logic [W-1:0] rate;
        brg_cfg_t     cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_in;
        if (we)
            st_d.rate = wdata;
        restart = we || (cfg_in != st_q.cfg) || !en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rate <= '1;
            st_q.cfg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_q   = st_q.rate;
    assign rate_nxt = st_d.rate;

endmodule

// File: rtl/brg_base_div.sv
module brg_base_div
    import brg_pkg::*;
#(
    parameter int W  = RATE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [SW-1:0] presc,
    input  logic [W-1:0]  rate_q,
    input  logic [W-1:0]  rate_nxt,
    output logic          base_tick
);

    localparam int PRE_W = 2 * ((1 << SW) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [W-1:0]     div;
    } state_t;

    state_t           st_d, st_q;
    logic [PRE_W-1:0] pre_last;
    logic             pre_wrap;

    always_comb begin
        st_d      = st_q;
        base_tick = 1'b0;
        pre_last  = PRE_W'((64'd1 << (2 * presc)) - 64'd1);
        pre_wrap  = (st_q.pre == pre_last);
        if (restart) begin
            st_d.pre = '0;
            st_d.div = rate_nxt;
        end else if (pre_wrap) begin
            st_d.pre = '0;
            if (st_q.div == '0) begin
                st_d.div  = rate_q;
                base_tick = 1'b1;
            end else begin
                st_d.div = st_q.div - 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre <= '0;
            st_q.div <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/brg_bit_cnt.sv
module brg_bit_cnt
    import brg_pkg::*;
#(
    parameter int FW = FIN_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          base_tick,
    input  brg_mode_e     mode,
    input  logic [SW-1:0] cycles,
    output logic          bit_stb,
    output logic          tick_stb,
    output logic          sub_stb
);

    typedef struct packed {
        logic [FW-1:0] fin;
        logic          bit_o;
        logic          tick_o;
        logic          sub_o;
    } state_t;

    state_t        st_d, st_q;
    logic [FW-1:0] len;
    logic          last;

    always_comb begin
        st_d        = st_q;
        st_d.bit_o  = 1'b0;
        st_d.tick_o = 1'b0;
        st_d.sub_o  = 1'b0;
        len         = ticks_per_bit(mode, cycles);
        last        = (st_q.fin == len - 1'b1);
        if (restart) begin
            st_d.fin = '0;
        end else if (base_tick) begin
            st_d.fin    = last ? '0 : st_q.fin + 1'b1;
            st_d.bit_o  = last;
            st_d.tick_o = (mode != MODE_SYNC);
            st_d.sub_o  = (mode == MODE_ASYNC) && st_q.fin[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_stb  = st_q.bit_o;
    assign tick_stb = st_q.tick_o;
    assign sub_stb  = st_q.sub_o;

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
    import brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic [RATE_W-1:0] rate_rdata,
    input  logic [SEL_W-1:0]  presc_sel,
    input  logic [SEL_W-1:0]  cycles_sel,
    input  logic              sync_sel,
    input  logic              card_sel,
    output logic              bit_stb,
    output logic              tick_stb,
    output logic              sub_stb
);

    brg_cfg_t          cfg;
    logic [RATE_W-1:0] rate_nxt;
    logic              restart;
    logic              base_tick;

    assign cfg.presc    = presc_sel;
    assign cfg.cycles   = cycles_sel;
    assign cfg.sync_bit = sync_sel;
    assign cfg.card_bit = card_sel;

    brg_cfg_track #(.W(RATE_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en),
        .we       (rate_we),
        .wdata    (rate_wdata),
        .cfg_in   (cfg),
        .rate_q   (rate_rdata),
        .rate_nxt (rate_nxt),
        .restart  (restart)
    );

    brg_base_div #(.W(RATE_W), .SW(SEL_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .presc     (presc_sel),
        .rate_q    (rate_rdata),
        .rate_nxt  (rate_nxt),
        .base_tick (base_tick)
    );

    brg_bit_cnt #(.FW(FIN_W), .SW(SEL_W)) i_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .base_tick (base_tick),
        .mode      (cfg_mode(cfg)),
        .cycles    (cycles_sel),
        .bit_stb   (bit_stb),
        .tick_stb  (tick_stb),
        .sub_stb   (sub_stb)
    );

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gen_en,
    input logic       rate_we,
    input logic [7:0] rate_wdata,
    input logic [7:0] rate_rdata,
    input logic [1:0] presc_sel,
    input logic [1:0] cycles_sel,
    input logic       sync_sel,
    input logic       card_sel,
    input logic       bit_stb,
    input logic       tick_stb,
    input logic       sub_stb
);

    p_rate_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rate_we |=> rate_rdata == $past(rate_wdata));

    p_sync_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_stb |-> $past(card_sel || !sync_sel));

    p_sub_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_stb |-> tick_stb);

    p_bit_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    p_bit_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && $past(card_sel || !sync_sel)) |-> tick_stb);

    p_write_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_we |=> !bit_stb && !tick_stb && !sub_stb);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !bit_stb && !tick_stb && !sub_stb);

endmodule

bind baud_rate_gen baud_rate_gen_chk i_chk (.*);

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = 8'h00;
    logic [1:0] presc_sel = 2'd0;
    logic [1:0] cycles_sel = 2'd0;
    logic       sync_sel = 1'b0;
    logic       card_sel = 1'b0;
    logic [7:0] rate_rdata;
    logic       bit_stb, tick_stb, sub_stb;

    always #4 clk = ~clk;

    baud_rate_gen i_baud_rate_gen (.*);

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string ctx = "R10";

    // Reference model: clocks since the last restart.
    int       m_cnt;
    logic [7:0] m_rate;
    logic [5:0] m_prev;
    bit       e_bit, e_tick, e_sub;
    string    mode_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_rate = 8'hFF;
            m_prev = '0;
            e_bit  = 0;
            e_tick = 0;
            e_sub  = 0;
        end else begin
            automatic logic [5:0] cur = {presc_sel, cycles_sel, sync_sel, card_sel};
            automatic bit rs = rate_we || (cur != m_prev) || !gen_en;
            automatic int tp, bp, len;
            if (rate_we) m_rate = rate_wdata;
            m_prev = cur;
            m_cnt  = rs ? 0 : m_cnt + 1;
            tp = (4 ** presc_sel) * (int'(m_rate) + 1);
            if (card_sel) begin
                case (cycles_sel)
                    2'd0: len = 16;
                    2'd1: len = 32;
                    2'd2: len = 186;
                    default: len = 128;
                endcase
            end else if (sync_sel) len = 4;
            else len = 32;
            bp = tp * len;
            e_bit  = (m_cnt > 0) && (m_cnt % bp == 0);
            e_tick = (m_cnt > 0) && (m_cnt % tp == 0) && (card_sel || !sync_sel);
            e_sub  = (m_cnt > 0) && (m_cnt % (2 * tp) == 0) && !card_sel && !sync_sel;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            mode_tag = card_sel ? "R5" : (sync_sel ? "R4" : "R3");
            n_cmp += 4;
            if (rate_rdata !== m_rate) begin
                n_bad++;
                $display("FAIL R1 (%s) rate_rdata act=%0h exp=%0h", ctx, rate_rdata, m_rate);
            end
            if (bit_stb !== e_bit) begin
                n_bad++;
                $display("FAIL %s (%s, R7) bit_stb act=%0b exp=%0b cnt=%0d", mode_tag, ctx, bit_stb, e_bit, m_cnt);
            end
            if (tick_stb !== e_tick) begin
                n_bad++;
                $display("FAIL R2 (%s) tick_stb act=%0b exp=%0b cnt=%0d", ctx, tick_stb, e_tick, m_cnt);
            end
            if (sub_stb !== e_sub) begin
                n_bad++;
                $display("FAIL R6 (%s) sub_stb act=%0b exp=%0b cnt=%0d", ctx, sub_stb, e_sub, m_cnt);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] p, input logic [1:0] c, input logic s, input logic k);
        presc_sel = p; cycles_sel = c; sync_sel = s; card_sel = k;
    endtask

    task automatic wr_rate(input logic [7:0] v);
        rate_we = 1'b1; rate_wdata = v;
        @(negedge clk);
        rate_we = 1'b0;
    endtask

    task automatic report;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R1, R10: reset values and reset-time settings
        ctx = "R10";
        set_cfg(2'd0, 2'd1, 1'b1, 1'b0);
        run(3);
        rst_n = 1'b1;
        run(4);
        // R4, R7: N=0, n=0 synchronous -> 4-clock period
        ctx = "R4";
        gen_en = 1'b1;
        wr_rate(8'h00);
        run(40);
        // R3, R6: asynchronous N=2
        ctx = "R3";
        set_cfg(2'd0, 2'd1, 1'b0, 1'b0);
        wr_rate(8'h02);
        run(250);
        // R2: prescaler n=1, N=1
        ctx = "R2";
        set_cfg(2'd1, 2'd1, 1'b0, 1'b0);
        wr_rate(8'h01);
        run(300);
        // R5: smart card each code, sync_sel high to check precedence
        ctx = "R5";
        wr_rate(8'h00);
        for (int c = 0; c < 4; c++) begin
            set_cfg(2'd0, c[1:0], 1'b1, 1'b1);
            run(400);
        end
        // R8: write in the middle of a period
        ctx = "R8";
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0);
        wr_rate(8'h03);
        run(57);
        wr_rate(8'h00);
        run(100);
        set_cfg(2'd1, 2'd0, 1'b0, 1'b0);
        run(30);
        // R9: generator disabled
        ctx = "R9";
        gen_en = 1'b0;
        run(60);
        gen_en = 1'b1;
        run(80);
        // R2: largest prescaler, synchronous
        ctx = "R2";
        set_cfg(2'd3, 2'd0, 1'b1, 1'b0);
        run(300);
        // R10: reset mid-run with non-zero settings held
        ctx = "R10";
        set_cfg(2'd0, 2'd2, 1'b0, 1'b1);
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(400);
        report();
    end

endmodule